// File: doc/BRIEF.md
# Dual-Bank Bus Cycle Sequencer

This block sits between an internal core and an external 16-bit memory or I/O space built from an even bank and an odd bank. It takes one request at a time through a valid/ready handshake. Each request is a byte or a word access, with a 3-bit cycle status that gives its kind. The block runs the matching external bus cycles on a multiplexed address/data bus. An address latch strobe marks the address phase, and an active-low high-bank enable works with address bit 0 to choose which byte lanes carry data.

A bus cycle has four phases: an address phase, a turnaround phase with the read or write strobe asserted, any number of wait states requested through the ready input, and a final data phase. A word at an odd address cannot be moved in one cycle. The block splits it into two cycles on consecutive addresses. For a read, it holds the first byte and returns the assembled word with a single response.

Top module: `bank_bus_sequencer`

## Requirements
- R1: After reset the block is idle. reqReady=1, ale=0, rdN=1, wrN=1, highEnN=1, busAdOe=0, rspValid=0 and cycStatus=3'b111.
- R2: A request is taken only while reqReady is high. reqReady stays low from the acceptance edge until the response, including both halves of a split access.
- R3: The cycle after acceptance is the address phase. ale is high for exactly that one cycle. busAdOe=1, busAdOut carries address bits 15..0 and busAddrHi carries the upper address bits.
- R4: A byte access at an even address runs one cycle with A0=0 and highEnN=1, on lane 7..0. Read data returns as {8'h00, busAdIn[7:0]}. Write data is driven on busAdOut[7:0].
- R5: A byte access at an odd address runs one cycle with A0=1 and highEnN=0, on lane 15..8. Read data returns as {8'h00, busAdIn[15:8]}. Write data byte 7..0 is driven on busAdOut[15:8].
- R6: A word access at an even address runs one cycle with A0=0 and highEnN=0, using all 16 lines.
- R7: A word access at an odd address runs two cycles. The first cycle uses the odd address with highEnN=0 and moves the low byte on lane 15..8. The second cycle uses the address plus one with highEnN=1 and moves the high byte on lane 7..0. A read returns {second-cycle lane 7..0, first-cycle lane 15..8} in one response after the second cycle.
- R8: ready is sampled at the end of the turnaround phase and at the end of every wait state. Each low sample adds one wait state, and the strobe stays asserted during wait states. Without waits, a single-cycle access responds 4 cycles after acceptance and a split access responds 7 cycles after acceptance. Each wait state adds one cycle.
- R9: cycStatus shows the request code during the cycle and 3'b111 when idle. Codes 010 (I/O write) and 110 (memory write) assert wrN and drive data with busAdOe=1. Codes 000, 001, 100 and 101 are reads that assert rdN. Code 011 (halt) asserts neither strobe.
- R10: rspValid is a one-cycle pulse in the cycle after the data phase of the last bus cycle. rspRdata holds the read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqStatus | input | 3 | Cycle status code of the request |
| reqWord | input | 1 | 1 = word access, 0 = byte access |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 16 | Write data; a byte uses bits 7..0 |
| rspValid | output | 1 | Response pulse |
| rspRdata | output | 16 | Read result, byte reads right-aligned |
| busAdOut | output | 16 | Multiplexed address/data out |
| busAdOe | output | 1 | Output enable for busAdOut |
| busAdIn | input | 16 | Data from the external bus |
| busAddrHi | output | ADDR_W-16 | Upper address bits |
| ale | output | 1 | Address latch strobe |
| highEnN | output | 1 | Active-low high-bank enable |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| ready | input | 1 | External ready, low inserts wait states |
| cycStatus | output | 3 | Status of the running cycle, 111 when idle |

## Verification
A wrong phase state shows up within one or two cycles. It appears as a second ale pulse, a strobe outside its window, or a response latency that differs from the count derived from cycles and wait states. A wrong split or lane selection shows up at the next address phase, as a bad address or bank enable. For writes it shows up one cycle later, on the data lanes. A lost held byte shows up only at the response of the split read, so every odd-word read compares the assembled word with data derived from the address.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_T1,
    PH_T2,
    PH_TW,
    PH_T4
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // take a new request
    logic addrPhase;  // drive address on the shared lines
    logic capture;    // end of data phase
    logic advance;    // move to second half of a split access
    logic active;     // a bus cycle is in progress
  } strobe_t;

  localparam logic [2:0] STAT_PASSIVE = 3'b111;
  localparam logic [2:0] STAT_HALT    = 3'b011;

  function automatic logic isWriteCode(input logic [2:0] code);
    return code[1:0] == 2'b10;
  endfunction
endpackage

// File: rtl/bbs_ctrl.sv
module bbs_ctrl
  import bbs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    ready,
  input  logic    splitFirst,
  input  logic    isWrite,
  input  logic    isHalt,
  output strobe_t strb,
  output logic    reqReady,
  output logic    ale,
  output logic    adOe,
  output logic    rdN,
  output logic    wrN,
  output logic    rspValid
);
  phase_e state, stateNext;
  logic   dataWin;

  always_comb begin
    stateNext = state;
    unique case (state)
      PH_IDLE: if (reqValid) stateNext = PH_T1;
      PH_T1:   stateNext = PH_T2;
      PH_T2:   stateNext = ready ? PH_T4 : PH_TW;
      PH_TW:   stateNext = ready ? PH_T4 : PH_TW;
      PH_T4:   stateNext = splitFirst ? PH_T1 : PH_IDLE;
      default: stateNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= PH_IDLE;
      rspValid <= 1'b0;
    end else begin
      state    <= stateNext;
      rspValid <= (state == PH_T4) && !splitFirst;
    end
  end

  assign dataWin       = (state == PH_T2) || (state == PH_TW) || (state == PH_T4);
  assign strb.load      = (state == PH_IDLE) && reqValid;
  assign strb.addrPhase = (state == PH_T1);
  assign strb.capture   = (state == PH_T4);
  assign strb.advance   = (state == PH_T4) && splitFirst;
  assign strb.active    = (state != PH_IDLE);

  assign reqReady = (state == PH_IDLE);
  assign ale      = (state == PH_T1);
  assign adOe     = (state == PH_T1) || (dataWin && isWrite);
  assign rdN      = !(dataWin && !isWrite && !isHalt);
  assign wrN      = !(dataWin && isWrite);

  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> !reqReady);
  p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (((state == PH_T2) || (state == PH_TW)) && !ready) |=> (state == PH_TW) && !(rdN && wrN && !isHalt));
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

// File: rtl/bbs_datapath.sv
module bbs_datapath
  import bbs_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWord,
  input  logic [2:0]          reqStatus,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   busAdIn,
  output logic                splitFirst,
  output logic                isWrite,
  output logic                isHalt,
  output logic [DATA_W-1:0]   adOutWord,
  output logic [ADDR_W-17:0]  addrUpper,
  output logic                highEnN,
  output logic [2:0]          cycStatus,
  output logic [DATA_W-1:0]   rspRdata
);
  localparam int HALF = DATA_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic              wordQ, oddQ, phaseQ;
  logic [2:0]        statusQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic [HALF-1:0]   heldQ;
  logic [DATA_W-1:0] wrLane, rdLane;
  logic              laneHiEnN;

  assign splitFirst = wordQ && oddQ && !phaseQ;
  assign isWrite    = isWriteCode(statusQ);
  assign isHalt     = (statusQ == STAT_HALT);

  always_comb begin
    laneHiEnN = 1'b1;
    wrLane    = {{HALF{1'b0}}, wdataQ[HALF-1:0]};
    rdLane    = {{HALF{1'b0}}, busAdIn[HALF-1:0]};
    unique casez ({wordQ, oddQ, phaseQ})
      3'b00?: begin
        laneHiEnN = 1'b1;
        wrLane    = {{HALF{1'b0}}, wdataQ[HALF-1:0]};
        rdLane    = {{HALF{1'b0}}, busAdIn[HALF-1:0]};
      end
      3'b01?: begin
        laneHiEnN = 1'b0;
        wrLane    = {wdataQ[HALF-1:0], {HALF{1'b0}}};
        rdLane    = {{HALF{1'b0}}, busAdIn[DATA_W-1:HALF]};
      end
      3'b10?: begin
        laneHiEnN = 1'b0;
        wrLane    = wdataQ;
        rdLane    = busAdIn;
      end
      3'b110: begin
        laneHiEnN = 1'b0;
        wrLane    = {wdataQ[HALF-1:0], {HALF{1'b0}}};
        rdLane    = busAdIn;
      end
      3'b111: begin
        laneHiEnN = 1'b1;
        wrLane    = {{HALF{1'b0}}, wdataQ[DATA_W-1:HALF]};
        rdLane    = {busAdIn[HALF-1:0], heldQ};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wordQ   <= 1'b0;
      oddQ    <= 1'b0;
      phaseQ  <= 1'b0;
      statusQ <= STAT_PASSIVE;
      wdataQ  <= '0;
      rdataQ  <= '0;
      heldQ   <= '0;
    end else begin
      if (strb.load) begin
        addrQ   <= reqAddr;
        wordQ   <= reqWord;
        oddQ    <= reqAddr[0];
        phaseQ  <= 1'b0;
        statusQ <= reqStatus;
        wdataQ  <= reqWdata;
      end
      if (strb.advance) begin
        addrQ  <= addrQ + 1'b1;
        phaseQ <= 1'b1;
      end
      if (strb.capture && !isWrite && !isHalt) begin
        if (splitFirst) heldQ <= busAdIn[DATA_W-1:HALF];
        else            rdataQ <= rdLane;
      end
    end
  end

  assign adOutWord = strb.addrPhase ? addrQ[DATA_W-1:0] : wrLane;
  assign addrUpper = addrQ[ADDR_W-1:16];
  assign highEnN   = strb.active ? laneHiEnN : 1'b1;
  assign cycStatus = strb.active ? statusQ : STAT_PASSIVE;
  assign rspRdata  = rdataQ;

  p_split_second_even_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addrPhase && phaseQ) |-> (!adOutWord[0] && highEnN));
  p_split_first_odd_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addrPhase && splitFirst) |-> (adOutWord[0] && !highEnN));
endmodule

// File: rtl/bank_bus_sequencer.sv
module bank_bus_sequencer
  import bbs_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqStatus,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  output logic              rspValid,
  output logic [15:0]       rspRdata,
  output logic [15:0]       busAdOut,
  output logic              busAdOe,
  input  logic [15:0]       busAdIn,
  output logic [ADDR_W-17:0] busAddrHi,
  output logic              ale,
  output logic              highEnN,
  output logic              rdN,
  output logic              wrN,
  input  logic              ready,
  output logic [2:0]        cycStatus
);
  strobe_t strb;
  logic    splitFirst, isWrite, isHalt;

  bbs_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .ready     (ready),
    .splitFirst(splitFirst),
    .isWrite   (isWrite),
    .isHalt    (isHalt),
    .strb      (strb),
    .reqReady  (reqReady),
    .ale       (ale),
    .adOe      (busAdOe),
    .rdN       (rdN),
    .wrN       (wrN),
    .rspValid  (rspValid)
  );

  bbs_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqWord   (reqWord),
    .reqStatus (reqStatus),
    .reqWdata  (reqWdata),
    .busAdIn   (busAdIn),
    .splitFirst(splitFirst),
    .isWrite   (isWrite),
    .isHalt    (isHalt),
    .adOutWord (busAdOut),
    .addrUpper (busAddrHi),
    .highEnN   (highEnN),
    .cycStatus (cycStatus),
    .rspRdata  (rspRdata)
  );
endmodule

// File: tb/sim_bank_bus_sequencer.sv
`timescale 1ns/1ps
module sim_bank_bus_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqStatus = 3'b101;
  logic        reqWord = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        rspValid;
  logic [15:0] rspRdata;
  logic [15:0] busAdOut;
  logic        busAdOe;
  logic [15:0] busAdIn;
  logic [3:0]  busAddrHi;
  logic        ale, highEnN, rdN, wrN;
  logic        ready;
  logic [2:0]  cycStatus;

  int checks = 0;
  int errors = 0;
  int curWaits = 0;
  int phaseCnt = 100;
  logic [19:0] latched = '0;

  typedef struct {
    logic [19:0] addr;
    logic        hi;
    logic [2:0]  st;
    logic        wr;
    logic [15:0] wd;
  } cyc_t;
  typedef struct {
    logic        chk;
    logic [15:0] d;
  } rsp_t;
  cyc_t cycQ[$];
  rsp_t rspQ[$];

  always #2 clk = ~clk;

  bank_bus_sequencer u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqStatus(reqStatus), .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .busAdOut(busAdOut), .busAdOe(busAdOe),
    .busAdIn(busAdIn), .busAddrHi(busAddrHi), .ale(ale), .highEnN(highEnN),
    .rdN(rdN), .wrN(wrN), .ready(ready), .cycStatus(cycStatus)
  );

  function automatic logic [7:0] bfn(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5 ^ {4'h0, a[19:16]};
  endfunction

  assign busAdIn = {bfn(latched | 20'h1), bfn(latched & ~20'h1)};
  assign ready   = (phaseCnt > curWaits);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus model and cycle monitor
  initial begin
    cyc_t cur;
    logic pendWr = 1'b0;
    forever begin
      @(negedge clk);
      if (ale) begin
        latched = {busAddrHi, busAdOut};
        phaseCnt = 0;
        if (cycQ.size() == 0) begin
          check(0, "R2 unexpected bus cycle", {12'h0, latched}, 0);
        end else begin
          cur = cycQ.pop_front();
          check({busAddrHi, busAdOut} == cur.addr, "R3/R7 cycle address", {12'h0, busAddrHi, busAdOut}, {12'h0, cur.addr});
          check(highEnN == cur.hi, "R4/R5/R6/R7 high bank enable", {31'h0, highEnN}, {31'h0, cur.hi});
          check(cycStatus == cur.st, "R9 cycle status", {29'h0, cycStatus}, {29'h0, cur.st});
          check(busAdOe == 1'b1, "R3 address drive enable", {31'h0, busAdOe}, 1);
          pendWr = cur.wr;
        end
      end else begin
        phaseCnt++;
        if (pendWr && !wrN) begin
          pendWr = 1'b0;
          check(busAdOe == 1'b1, "R9 write drive enable", {31'h0, busAdOe}, 1);
          if (!cur.addr[0])
            check(busAdOut[7:0] == cur.wd[7:0], "R4/R6/R7 low lane write", {24'h0, busAdOut[7:0]}, {24'h0, cur.wd[7:0]});
          if (!cur.hi)
            check(busAdOut[15:8] == cur.wd[15:8], "R5/R6/R7 high lane write", {24'h0, busAdOut[15:8]}, {24'h0, cur.wd[15:8]});
        end
      end
    end
  end

  // response scoreboard
  initial begin
    rsp_t e;
    forever begin
      @(negedge clk);
      if (rspValid) begin
        if (rspQ.size() == 0) begin
          check(0, "R10 unexpected response", 0, 0);
        end else begin
          e = rspQ.pop_front();
          if (e.chk)
            check(rspRdata == e.d, "R4/R5/R6/R7 read data", {16'h0, rspRdata}, {16'h0, e.d});
        end
      end
    end
  end

  task automatic doReq(input logic [2:0] st, input logic word, input logic [19:0] a,
                       input logic [15:0] w, input int waits);
    cyc_t c;
    rsp_t r;
    bit wr = (st[1:0] == 2'b10);
    bit halt = (st == 3'b011);
    int nCyc = (word && a[0]) ? 2 : 1;
    int lat = 0;
    bit sawStrobe = 0;
    bit readyBad = 0;
    c.st = st; c.wr = wr;
    if (!word) begin
      c.addr = a; c.hi = !a[0];
      c.wd = a[0] ? {w[7:0], 8'h00} : {8'h00, w[7:0]};
      cycQ.push_back(c);
    end else if (!a[0]) begin
      c.addr = a; c.hi = 1'b0; c.wd = w;
      cycQ.push_back(c);
    end else begin
      c.addr = a; c.hi = 1'b0; c.wd = {w[7:0], 8'h00};
      cycQ.push_back(c);
      c.addr = a + 20'h1; c.hi = 1'b1; c.wd = {8'h00, w[15:8]};
      cycQ.push_back(c);
    end
    r.chk = !wr && !halt;
    r.d = word ? {bfn(a + 20'h1), bfn(a)} : {8'h00, bfn(a)};
    rspQ.push_back(r);

    @(negedge clk);
    curWaits = waits;
    check(reqReady == 1'b1, "R2 ready when idle", {31'h0, reqReady}, 1);
    reqStatus = st; reqWord = word; reqAddr = a; reqWdata = w; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr = 20'hFFFFF; reqWdata = 16'hDEAD;
    lat = 1;
    while (!rspValid && lat < 100) begin
      if (reqReady) readyBad = 1;
      if (!rdN || !wrN) sawStrobe = 1;
      @(negedge clk);
      lat++;
    end
    check(!readyBad, "R2 ready low while busy", {31'h0, readyBad}, 0);
    check(lat == nCyc * (3 + waits) + 1, "R8 response latency", lat, nCyc * (3 + waits) + 1);
    if (halt) check(!sawStrobe, "R9 halt has no strobe", {31'h0, sawStrobe}, 0);
    else      check(sawStrobe, "R9 strobe asserted", {31'h0, sawStrobe}, 1);
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady && !ale && rdN && wrN && highEnN && !busAdOe && !rspValid && cycStatus == 3'b111,
          "R1 reset state", {25'h0, reqReady, ale, rdN, wrN, highEnN, busAdOe, rspValid},
          {25'h0, 7'b1011100});
    rstN = 1'b1;
    @(negedge clk);
    check(cycStatus == 3'b111, "R1 idle status after reset", {29'h0, cycStatus}, 7);

    doReq(3'b101, 1'b0, 20'h12344, 16'h0, 0);   // R4 even byte read
    doReq(3'b101, 1'b0, 20'h12345, 16'h0, 1);   // R5 odd byte read, one wait
    doReq(3'b101, 1'b1, 20'h0ABC0, 16'h0, 0);   // R6 even word read
    doReq(3'b101, 1'b1, 20'h0ABC1, 16'h0, 0);   // R7 split read
    doReq(3'b100, 1'b1, 20'h1FFFF, 16'h0, 2);   // R7 split crossing 64K, R8 waits
    doReq(3'b110, 1'b0, 20'h00010, 16'h3C5A, 0);// R4 even byte write
    doReq(3'b110, 1'b0, 20'h00011, 16'h3C7E, 3);// R5 odd byte write
    doReq(3'b110, 1'b1, 20'h40002, 16'hBEEF, 0);// R6 even word write
    doReq(3'b010, 1'b1, 20'h00203, 16'hCAFE, 1);// R7 split io write
    doReq(3'b001, 1'b0, 20'h00061, 16'h0, 0);   // R9 io read
    doReq(3'b000, 1'b0, 20'h00000, 16'h0, 0);   // R9 interrupt ack
    doReq(3'b011, 1'b0, 20'h00002, 16'h0, 0);   // R9 halt
    doReq(3'b101, 1'b1, 20'hFFFFF, 16'h0, 0);   // R7 wrap of address
    @(negedge clk);
    check(cycStatus == 3'b111 && highEnN && rdN && wrN, "R9 idle after traffic",
          {28'h0, cycStatus, highEnN}, {28'h0, 4'b1111});
    check(!rspValid, "R10 single pulse", {31'h0, rspValid}, 0);
    check(cycQ.size() == 0 && rspQ.size() == 0, "R2/R10 all items consumed",
          cycQ.size() + rspQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule